// File: doc/BRIEF.md
# PCI Initiator Termination Controller

This block sits beside the initiator state of a PCI bridge. It decides when a transaction the bridge drives on the target bus ends, and how it ends. A transaction is launched with its kind and its buffered length in DWORDs. The block then drives the cycle-framing and initiator-ready lines, which are active low. It watches the target's claim, ready and stop lines, and follows the latency-timer expiry, the bus grant and a prefetch-boundary flag supplied by the data path.

When the transaction ends, the block pulses a done strobe for one cycle. With the strobe it gives a one-hot termination cause and the number of DWORDs delivered. A posted write cut short by the latency timer also raises a resume request; the delivered count is then the DWORD offset where the follow-on transaction must start. A master abort sets a sticky received-master-abort status bit. Address generation, data movement, arbitration and configuration space are handled elsewhere.

Top module: `pci_init_term`

## Requirements
- R1: While reset is asserted and right after it, `cyc_no` and `init_rdy_no` are 1, `busy_o`, `done_o`, `resume_o` and `rx_mabort_o` are 0.
- R2: `start_i` sampled high while idle begins an address cycle (`cyc_no`=0, `init_rdy_no`=1), followed by data cycles with `init_rdy_no`=0. Kind encodings on `kind_i`: 0 delayed write, 1 non-prefetchable read, 2 prefetchable read, 3 posted write, 4 memory write and invalidate; values 5..7 behave as 0. Kinds 0 and 1 end after one transfer with cause NORMAL, and `cyc_no` is already 1 during their data phase while `init_rdy_no` stays 0.
- R3: Kinds 3 and 4 end with cause NORMAL on the transfer that delivers the `len_i`-th DWORD (`len_i` >= 1). Kind 2 ends with cause NORMAL on the transfer made while `pf_boundary_i` is high.
- R4: For kinds 2 and 3, when `lat_expired_i` is 1 and `gnt_i` is 0, the current transfer becomes the last one, with cause LATCUT. If the natural end of R3 falls on the same transfer, the cause is NORMAL. Kind 4 ignores the latency timer, and expiry with grant still high cuts nothing.
- R5: A kind 3 transaction ended by LATCUT raises `resume_o` with the done pulse, and `delivered_o` is then the offset of the next undelivered DWORD. A kind 2 transaction ended by LATCUT does not raise `resume_o`.
- R6: Stop, claim and ready all asserted together in a data cycle complete that transfer and end the transaction with cause DISC_DATA.
- R7: Stop and claim asserted with ready deasserted end the transaction without a transfer. The cause is RETRY if no DWORD was delivered yet, otherwise DISC_NODATA.
- R8: Stop asserted with claim and ready deasserted gives cause TABORT if claim was seen in an earlier cycle of the transaction. If claim was never seen, the stop is ignored.
- R9: If claim is not seen in any of the first MA_CLKS (default 5) cycles with `cyc_no` asserted, counting the address cycle as the first, the transaction ends with cause MABORT and `done_o` rises in the next cycle. Claim seen in the fifth cycle is accepted. A master abort sets `rx_mabort_o`, which stays 1 until reset.
- R10: `done_o` is a one-cycle pulse in the cycle after the terminating edge. In that cycle `cyc_no` and `init_rdy_no` are both 1, `delivered_o` holds the DWORDs moved, and `cause_o` is one-hot: bit0 NORMAL, bit1 LATCUT, bit2 DISC_DATA, bit3 DISC_NODATA, bit4 RETRY, bit5 TABORT, bit6 MABORT. `cause_o` is 0 when `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a transaction (taken only when idle) |
| kind_i | input | 3 | Transaction kind, encoded as in R2 |
| len_i | input | CNT_W | Buffered DWORDs for kinds 3 and 4 |
| pf_boundary_i | input | 1 | Current data phase reaches the prefetch boundary |
| lat_expired_i | input | 1 | Master latency timer has expired |
| gnt_i | input | 1 | Bus grant, active high |
| claim_ni | input | 1 | Target claims the transaction, active low |
| tgt_rdy_ni | input | 1 | Target ready, active low |
| tgt_stop_ni | input | 1 | Target requests stop, active low |
| cyc_no | output | 1 | Cycle framing, active low |
| init_rdy_no | output | 1 | Initiator ready, active low |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle termination strobe |
| cause_o | output | 7 | One-hot termination cause |
| resume_o | output | 1 | Follow-on posted write required |
| delivered_o | output | CNT_W | DWORDs transferred in this transaction |
| rx_mabort_o | output | 1 | Sticky received-master-abort status |

## Verification
The bench puts claim in the fifth framed cycle and claim that never arrives side by side. An off-by-one window would then abort a legal transaction or hang one that should abort. It makes the latency cutoff land on the same transfer as a posted write's natural end: that must report NORMAL without a resume, while a real cutoff must resume at the right DWORD offset. A prefetch read cut by the timer must not ask for a resume. The bench also tells retry from disconnect-without-data by the delivered count, and raises stop with claim never seen. A design that took that stop for a target abort would report TABORT where MABORT is due.

// File: rtl/pcit_pkg.sv
package pcit_pkg;
  typedef enum logic [2:0] {
    K_DLY_WR  = 3'd0,
    K_NP_RD   = 3'd1,
    K_PF_RD   = 3'd2,
    K_POST_WR = 3'd3,
    K_MWI     = 3'd4
  } kind_e;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_DONE} st_e;

  typedef enum logic [2:0] {
    RS_NONE, RS_XFER, RS_DISC_DATA, RS_STOP_NODATA, RS_ABORT
  } resp_e;

  localparam int CAUSE_W   = 7;
  localparam int C_NORMAL  = 0;
  localparam int C_LATCUT  = 1;
  localparam int C_DISC_D  = 2;
  localparam int C_DISC_ND = 3;
  localparam int C_RETRY   = 4;
  localparam int C_TABORT  = 5;
  localparam int C_MABORT  = 6;
endpackage

// File: rtl/pcit_claim_timer.sv
module pcit_claim_timer #(
  parameter int MA_CLKS = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic claim_i,
  output logic seen_o,
  output logic expire_o
);
  localparam int CW = $clog2(MA_CLKS + 1);
  logic [CW-1:0] cnt_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (run_i) begin
      if (claim_i) seen_q <= 1'b1;
      else if (!seen_q && cnt_q != CW'(MA_CLKS)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign seen_o   = seen_q;
  // last cycle of the window still without a claim
  assign expire_o = run_i && !seen_q && !claim_i && (cnt_q == CW'(MA_CLKS - 1));
endmodule

// File: rtl/pcit_resp_decode.sv
module pcit_resp_decode
  import pcit_pkg::*;
(
  input  logic  data_i,
  input  logic  claim_i,
  input  logic  rdy_i,
  input  logic  stop_i,
  input  logic  seen_i,
  output resp_e resp_o
);
  always_comb begin
    resp_o = RS_NONE;
    if (data_i) begin
      if (claim_i) begin
        if (stop_i && rdy_i)  resp_o = RS_DISC_DATA;
        else if (stop_i)      resp_o = RS_STOP_NODATA;
        else if (rdy_i)       resp_o = RS_XFER;
      end else if (stop_i && seen_i) begin
        resp_o = RS_ABORT;
      end
    end
  end
endmodule

// File: rtl/pcit_last_phase.sv
module pcit_last_phase
  import pcit_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  kind_e            kind_i,
  input  logic [CNT_W-1:0] rem_i,
  input  logic             pfb_i,
  input  logic             lat_i,
  input  logic             gnt_i,
  output logic             nat_o,
  output logic             cut_o
);
  logic lat_cut;
  assign lat_cut = lat_i && !gnt_i;

  always_comb begin
    case (kind_i)
      K_PF_RD:   begin nat_o = pfb_i;               cut_o = lat_cut; end
      K_POST_WR: begin nat_o = (rem_i == CNT_W'(1)); cut_o = lat_cut; end
      K_MWI:     begin nat_o = (rem_i == CNT_W'(1)); cut_o = 1'b0;    end
      default:   begin nat_o = 1'b1;                cut_o = 1'b0;    end
    endcase
  end
endmodule

// File: rtl/pci_init_term.sv
module pci_init_term
  import pcit_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MA_CLKS = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [2:0]         kind_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic               pf_boundary_i,
  input  logic               lat_expired_i,
  input  logic               gnt_i,
  input  logic               claim_ni,
  input  logic               tgt_rdy_ni,
  input  logic               tgt_stop_ni,
  output logic               cyc_no,
  output logic               init_rdy_no,
  output logic               busy_o,
  output logic               done_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               resume_o,
  output logic [CNT_W-1:0]   delivered_o,
  output logic               rx_mabort_o
);
  st_e                st_q;
  kind_e              kind_q;
  logic [CNT_W-1:0]   rem_q, dlv_q;
  logic               nat_q, cut_q, resume_q, mab_q;
  logic [CAUSE_W-1:0] cause_q;

  logic in_addr, in_data, seen, expire, nat_now, cut_now, nat_eff, cut_eff;
  logic term, resume_d, moved;
  logic [CAUSE_W-1:0] cause_d;
  resp_e resp;

  assign in_addr = (st_q == S_ADDR);
  assign in_data = (st_q == S_DATA);

  pcit_claim_timer #(.MA_CLKS(MA_CLKS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    ((st_q == S_IDLE) && start_i),
    .run_i    (in_addr || in_data),
    .claim_i  (!claim_ni),
    .seen_o   (seen),
    .expire_o (expire)
  );

  pcit_resp_decode u_dec (
    .data_i  (in_data),
    .claim_i (!claim_ni),
    .rdy_i   (!tgt_rdy_ni),
    .stop_i  (!tgt_stop_ni),
    .seen_i  (seen),
    .resp_o  (resp)
  );

  pcit_last_phase #(.CNT_W(CNT_W)) u_last (
    .kind_i (kind_q),
    .rem_i  (rem_q),
    .pfb_i  (pf_boundary_i),
    .lat_i  (lat_expired_i),
    .gnt_i  (gnt_i),
    .nat_o  (nat_now),
    .cut_o  (cut_now)
  );

  // once the last phase is decided it stays decided
  assign nat_eff = nat_now || nat_q;
  assign cut_eff = cut_now || cut_q;

  always_comb begin
    term     = 1'b0;
    moved    = 1'b0;
    resume_d = 1'b0;
    cause_d  = '0;
    case (resp)
      RS_XFER: begin
        moved = 1'b1;
        if (nat_eff || cut_eff) begin
          term = 1'b1;
          if (nat_eff) cause_d[C_NORMAL] = 1'b1;
          else begin
            cause_d[C_LATCUT] = 1'b1;
            resume_d = (kind_q == K_POST_WR);
          end
        end
      end
      RS_DISC_DATA: begin
        moved = 1'b1;
        term  = 1'b1;
        cause_d[C_DISC_D] = 1'b1;
      end
      RS_STOP_NODATA: begin
        term = 1'b1;
        if (dlv_q == '0) cause_d[C_RETRY]   = 1'b1;
        else             cause_d[C_DISC_ND] = 1'b1;
      end
      RS_ABORT: begin
        term = 1'b1;
        cause_d[C_TABORT] = 1'b1;
      end
      default: ;
    endcase
    if (!term && expire) begin
      term = 1'b1;
      cause_d[C_MABORT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      kind_q   <= K_DLY_WR;
      rem_q    <= '0;
      dlv_q    <= '0;
      nat_q    <= 1'b0;
      cut_q    <= 1'b0;
      resume_q <= 1'b0;
      cause_q  <= '0;
      mab_q    <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q     <= S_ADDR;
          kind_q   <= (kind_i > 3'd4) ? K_DLY_WR : kind_e'(kind_i);
          rem_q    <= len_i;
          dlv_q    <= '0;
          nat_q    <= 1'b0;
          cut_q    <= 1'b0;
          resume_q <= 1'b0;
          cause_q  <= '0;
        end
        S_ADDR, S_DATA: begin
          if (moved) begin
            dlv_q <= dlv_q + 1'b1;
            if (rem_q != '0) rem_q <= rem_q - 1'b1;
          end
          if (term) begin
            st_q     <= S_DONE;
            cause_q  <= cause_d;
            resume_q <= resume_d;
            if (cause_d[C_MABORT]) mab_q <= 1'b1;
          end else if (in_addr) begin
            st_q <= S_DATA;
          end else begin
            nat_q <= nat_eff;
            cut_q <= cut_eff;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign cyc_no      = !(in_addr || (in_data && !(nat_eff || cut_eff)));
  assign init_rdy_no = !in_data;
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_DONE);
  assign cause_o     = done_o ? cause_q : '0;
  assign resume_o    = done_o && resume_q;
  assign delivered_o = dlv_q;
  assign rx_mabort_o = mab_q;
endmodule

// File: rtl/pci_init_term_chk.sv
module pci_init_term_chk
  import pcit_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cyc_no,
  input logic               init_rdy_no,
  input logic               done_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               resume_o,
  input logic [CNT_W-1:0]   delivered_o,
  input logic               rx_mabort_o
);
  // R10
  cause_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones(cause_o) == 1));
  // R10
  cause_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (cause_o == '0));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  done_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cyc_no && init_rdy_no));
  // R2
  frame_stays_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_no && !init_rdy_no) |=> cyc_no);
  // R2
  addr_then_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cyc_no && init_rdy_no) |=> (!init_rdy_no || done_o));
  // R5
  resume_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (done_o && cause_o[C_LATCUT]));
  // R7
  retry_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cause_o[C_RETRY]) |-> (delivered_o == '0));
  // R9
  mabort_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cause_o[C_MABORT]) |-> rx_mabort_o);
  // R9
  mabort_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_mabort_o |=> rx_mabort_o);
endmodule

bind pci_init_term pci_init_term_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/pci_init_term_tb_top.sv
module pci_init_term_tb_top;
  localparam int CNT_W = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] kind_i = '0;
  logic [CNT_W-1:0] len_i = '0;
  logic pf_boundary_i = 1'b0, lat_expired_i = 1'b0, gnt_i = 1'b1;
  logic claim_ni = 1'b1, tgt_rdy_ni = 1'b1, tgt_stop_ni = 1'b1;
  logic cyc_no, init_rdy_no, busy_o, done_o, resume_o, rx_mabort_o;
  logic [6:0] cause_o;
  logic [CNT_W-1:0] delivered_o;

  int n_run = 0, n_fail = 0;

  typedef struct {
    logic [6:0] cause;
    int         dlv;
    bit         res;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk_i = ~clk_i;  // 250 MHz

  pci_init_term #(.CNT_W(CNT_W), .MA_CLKS(5)) dut_i (.*);

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  // monitor: compare each termination with the scoreboard head
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (sb_q.size() == 0) check(1'b0, "R10 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(cause_o == e.cause, {e.tag, " cause"}, int'(cause_o), int'(e.cause));
        check(delivered_o == CNT_W'(e.dlv), {e.tag, " delivered"}, int'(delivered_o), e.dlv);
        check(resume_o == e.res, {e.tag, " resume"}, int'(resume_o), int'(e.res));
      end
    end
  end

  // driver: target model plus expected result
  task automatic run_txn(input logic [2:0] k, input int len, input int claim_at,
                         input int stop_mode, input int stop_at, input int pfb_at,
                         input int lat_at, input bit keep_gnt, input int frm_n2,
                         input logic [6:0] exp_cause, input int exp_dlv,
                         input bit exp_res, input string tag);
    int xf = 0;
    bit fin = 1'b0;
    exp_t e;
    e.cause = exp_cause; e.dlv = exp_dlv; e.res = exp_res; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk_i);
    start_i = 1'b1; kind_i = k; len_i = CNT_W'(len);
    @(negedge clk_i);
    start_i = 1'b0;
    check(!cyc_no && init_rdy_no, {"R2 address cycle ", tag}, int'({cyc_no, init_rdy_no}), 1);
    for (int n = 1; n <= 40 && !fin; n++) begin
      bit claim, at_stop, rdy, moved;
      claim   = (claim_at > 0) && (n >= claim_at);
      at_stop = (stop_mode != 0) && (xf == stop_at) && (n >= 2);
      rdy     = claim && (n >= 2) && !(at_stop && stop_mode != 1);
      if (at_stop && stop_mode == 3) begin claim = 1'b0; rdy = 1'b0; end
      claim_ni = !claim; tgt_rdy_ni = !rdy; tgt_stop_ni = !at_stop;
      pf_boundary_i = (xf == pfb_at);
      lat_expired_i = (lat_at >= 0) && (xf >= lat_at);
      gnt_i = keep_gnt || !lat_expired_i;
      moved = (n >= 2) && claim && rdy;
      if (n == 2 && frm_n2 != 2) begin
        #1;
        check(cyc_no == frm_n2[0] && !init_rdy_no, {"R2 data phase framing ", tag},
              int'(cyc_no), frm_n2);
      end
      @(negedge clk_i);
      if (moved) xf++;
      if (done_o) begin
        fin = 1'b1;
        check(cyc_no && init_rdy_no, {"R10 lines released ", tag},
              int'({cyc_no, init_rdy_no}), 3);
      end
    end
    if (!fin) check(1'b0, {"R10 watchdog ", tag}, 0, 1);
    claim_ni = 1'b1; tgt_rdy_ni = 1'b1; tgt_stop_ni = 1'b1;
    pf_boundary_i = 1'b0; lat_expired_i = 1'b0; gnt_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(cyc_no && init_rdy_no && !busy_o && !done_o && !resume_o && !rx_mabort_o,
          "R1 reset state", int'({cyc_no, init_rdy_no, busy_o, done_o}), 12);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cyc_no && init_rdy_no && !busy_o && !rx_mabort_o, "R1 after reset",
          int'({cyc_no, init_rdy_no, busy_o}), 6);

    // args: kind len claim_at stop_mode stop_at pfb_at lat_at keep_gnt frm_n2 cause dlv res tag
    run_txn(3'd0, 1, 2, 0, 0, -1, -1, 0, 1, 7'h01, 1, 0, "R2 delayed write");
    run_txn(3'd1, 1, 1, 0, 0, -1, -1, 0, 1, 7'h01, 1, 0, "R2 np read");
    run_txn(3'd6, 1, 1, 0, 0, -1, -1, 0, 1, 7'h01, 1, 0, "R2 reserved kind");
    run_txn(3'd3, 4, 2, 0, 0, -1, -1, 0, 0, 7'h01, 4, 0, "R3 posted full");
    run_txn(3'd4, 5, 1, 0, 0, -1,  0, 0, 0, 7'h01, 5, 0, "R4 mwi ignores timer");
    run_txn(3'd2, 8, 2, 0, 0,  3, -1, 0, 0, 7'h01, 4, 0, "R3 prefetch boundary");
    run_txn(3'd3, 6, 2, 0, 0, -1,  2, 0, 0, 7'h02, 3, 1, "R5 posted latcut resume");
    run_txn(3'd3, 3, 2, 0, 0, -1,  2, 0, 0, 7'h01, 3, 0, "R4 cut on natural end");
    run_txn(3'd3, 4, 2, 0, 0, -1,  0, 1, 0, 7'h01, 4, 0, "R4 grant kept");
    run_txn(3'd2, 8, 2, 0, 0, -1,  1, 0, 0, 7'h02, 2, 0, "R5 prefetch latcut");
    run_txn(3'd3, 8, 2, 1, 2, -1, -1, 0, 0, 7'h04, 3, 0, "R6 disconnect with data");
    run_txn(3'd3, 8, 2, 2, 2, -1, -1, 0, 0, 7'h08, 2, 0, "R7 disconnect no data");
    run_txn(3'd2, 8, 2, 2, 0, -1, -1, 0, 2, 7'h10, 0, 0, "R7 retry");
    run_txn(3'd3, 8, 2, 3, 1, -1, -1, 0, 0, 7'h20, 1, 0, "R8 target abort");
    run_txn(3'd0, 1, 5, 0, 0, -1, -1, 0, 1, 7'h01, 1, 0, "R9 claim in fifth cycle");
    check(!rx_mabort_o, "R9 status clear before abort", int'(rx_mabort_o), 0);
    run_txn(3'd3, 4, 0, 3, 0, -1, -1, 0, 0, 7'h40, 0, 0, "R8 stop without claim ignored");
    check(rx_mabort_o, "R9 status set", int'(rx_mabort_o), 1);
    run_txn(3'd1, 1, 0, 0, 0, -1, -1, 0, 1, 7'h40, 0, 0, "R9 master abort");
    check(rx_mabort_o, "R9 status sticky", int'(rx_mabort_o), 1);

    repeat (2) @(negedge clk_i);
    check(sb_q.size() == 0, "R10 all terminations seen", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule